// File: doc/BRIEF.md
# Message Padder and Block Fetcher for a 160-bit Hash Engine

This block sits between a read-only, word-wide synchronous memory holding a byte message and a hash compression core. The core consumes 512-bit blocks. After a one-cycle start pulse carrying a word start address and a byte count, the block reads the message word by word. It swaps each little-endian memory word into big-endian message order. It then streams sixteen 32-bit words per block over a valid/ready handshake. While streaming it inserts the terminating 0x80 byte, zero fill and the 64-bit bit-length field. Every word of the final block is flagged.

The block works out the number of blocks from the byte count alone. The count is `((bytes + 8) / 64) + 1` blocks. A message that leaves fewer than 9 free bytes in its last block therefore spills into one extra block holding only zero fill and the length. Words that carry no message bytes never touch memory. Words that do carry message bytes are read with one cycle of latency. While the consumer stalls, the block holds the address steady so that the read data stays stable.

Top module: `msg_block_feeder`

## Requirements
- R1: A message of N bytes yields exactly `((N+8) div 64) + 1` blocks of 16 words each. `blk_idx` gives the word position in its block, counting from 0 to 15 and wrapping. `blk_last` is 1 on all 16 words of the final block and 0 on every other word. `busy` drops after the final word is accepted.
- R2: Stream word k, for k < N div 4, equals memory word at address base+k with its bytes reversed: `{d[7:0], d[15:8], d[23:16], d[31:24]}`.
- R3: When N mod 4 = r ≠ 0, word N div 4 keeps the first r swapped bytes in its upper byte lanes. The 0x80 byte follows in the next lane down, and the lower lanes are zero.
- R4: When N mod 4 = 0, word N div 4 is 0x80000000 and needs no memory read.
- R5: Every word after the marker word and before the last two words is zero.
- R6: The last two words of the stream hold N×8 as a 64-bit big-endian value. The upper half comes first.
- R7: When N mod 64 ≥ 56, the length field goes into an extra block whose words before the length are all zero.
- R8: A word that needs memory becomes valid two cycles after the start edge, or two cycles after the previous accepted word. A word that needs no memory becomes valid one cycle after that edge. While valid is high and ready is low, `mem_addr` and `blk_word` hold their values.
- R9: A start pulse while `busy` is 1 is ignored, and the stream in progress is unchanged.
- R10: After reset, `blk_valid` and `busy` are 0.
- R11: A zero-byte message yields exactly one block. Its first word is 0x80000000, its length words are 0, and its first word is valid one cycle after start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; sampled only when idle |
| msg_base | input | 32 | Word address of the first message word (low MEM_AW bits used) |
| msg_bytes | input | 32 | Message length in bytes |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 32 | Memory read data, one cycle after address |
| blk_valid | output | 1 | Stream word valid |
| blk_ready | input | 1 | Consumer accepts the word |
| blk_word | output | 32 | Big-endian stream word |
| blk_idx | output | 4 | Word position in the current block |
| blk_last | output | 1 | Word belongs to the final block |
| busy | output | 1 | A message is being streamed |

## Verification
After the start edge, the first word is due at the second falling edge if it needs a memory read. For a zero-byte message it is due at the first falling edge. After each accepted word, the next one follows with the same one- or two-cycle spacing. The bench drives inputs and samples outputs only on falling clock edges. It counts a word as accepted only when valid and ready are both high at the falling edge before the rising edge that transfers it. Stall checks compare the address and word across several consecutive falling edges with ready held low. The expected words come from a byte-level model of the padded message in the bench, not from word arithmetic.

// File: rtl/mbf_pkg.sv
package mbf_pkg;
  localparam int LEN_W     = 32;
  localparam int BLK_WORDS = 16;
  localparam int IDX_W     = $clog2(BLK_WORDS);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_EMIT} feed_state_t;

  // little-endian storage word -> big-endian message word
  function automatic logic [31:0] swap_bytes(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  // total stream words: 16 * (((n + 8) >> 6) + 1)
  function automatic logic [LEN_W-1:0] words_for(input logic [LEN_W-1:0] n);
    logic [LEN_W:0] blocks;
    blocks = (({1'b0, n} + (LEN_W+1)'(8)) >> 6) + (LEN_W+1)'(1);
    return blocks[LEN_W-1:0] << IDX_W;
  endfunction

  // does stream word k carry any message byte
  function automatic logic needs_read(input logic [LEN_W-1:0] k,
                                      input logic [LEN_W-1:0] full,
                                      input logic [1:0] rem);
    return (k < full) || ((k == full) && (rem != 2'd0));
  endfunction

  // partial last word: keep rem bytes, then marker, then zeros
  function automatic logic [31:0] tail_word(input logic [31:0] s, input logic [1:0] rem);
    logic [31:0] t;
    case (rem)
      2'd1:    t = {s[31:24], 8'h80, 16'h0000};
      2'd2:    t = {s[31:16], 8'h80, 8'h00};
      2'd3:    t = {s[31:8], 8'h80};
      default: t = 32'h8000_0000;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/mbf_word_former.sv
module mbf_word_former
  import mbf_pkg::*;
(
  input  logic [LEN_W-1:0] k_idx,
  input  logic [LEN_W-1:0] full_words,
  input  logic [1:0]       rem_bytes,
  input  logic [LEN_W-1:0] total_words,
  input  logic [LEN_W-1:0] byte_len,
  input  logic [31:0]      rdata,
  output logic [31:0]      word,
  output logic             needs_mem,
  output logic             is_len_word
);
  logic [63:0] bit_len;
  logic [31:0] swapped;
  logic        len_hi, len_lo;

  assign bit_len  = {{(64-LEN_W-3){1'b0}}, byte_len, 3'b000};
  assign swapped  = swap_bytes(rdata);
  assign len_hi   = (k_idx == total_words - LEN_W'(2));
  assign len_lo   = (k_idx == total_words - LEN_W'(1));
  assign is_len_word = len_hi || len_lo;
  assign needs_mem   = needs_read(k_idx, full_words, rem_bytes);

  always_comb begin
    if (k_idx < full_words)       word = swapped;
    else if (k_idx == full_words) word = tail_word(swapped, rem_bytes);
    else if (len_hi)              word = bit_len[63:32];
    else if (len_lo)              word = bit_len[31:0];
    else                          word = 32'h0;
  end
endmodule

// File: rtl/mbf_seq_ctrl.sv
module mbf_seq_ctrl
  import mbf_pkg::*;
#(
  parameter int MEM_AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       msg_base,
  input  logic [LEN_W-1:0]  msg_bytes,
  input  logic              blk_ready,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              blk_valid,
  output logic              busy,
  output logic              blk_last,
  output logic [IDX_W-1:0]  blk_idx,
  output logic [LEN_W-1:0]  k_q,
  output logic [LEN_W-1:0]  full_q,
  output logic [1:0]        rem_q,
  output logic [LEN_W-1:0]  total_q,
  output logic [LEN_W-1:0]  bytes_q
);
  feed_state_t       st;
  logic [MEM_AW-1:0] base_q;
  logic              fire, final_word;
  logic [LEN_W-1:0]  k_next;

  assign fire       = blk_valid && blk_ready;
  assign final_word = (k_q == total_q - LEN_W'(1));
  assign k_next     = k_q + LEN_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      base_q  <= '0;
      k_q     <= '0;
      full_q  <= '0;
      rem_q   <= '0;
      total_q <= '0;
      bytes_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          base_q  <= msg_base[MEM_AW-1:0];
          bytes_q <= msg_bytes;
          full_q  <= msg_bytes >> 2;
          rem_q   <= msg_bytes[1:0];
          total_q <= words_for(msg_bytes);
          k_q     <= '0;
          st      <= needs_read('0, msg_bytes >> 2, msg_bytes[1:0]) ? ST_LOAD : ST_EMIT;
        end
        ST_LOAD: st <= ST_EMIT;
        ST_EMIT: if (blk_ready) begin
          if (final_word) st <= ST_IDLE;
          else begin
            k_q <= k_next;
            st  <= needs_read(k_next, full_q, rem_q) ? ST_LOAD : ST_EMIT;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mem_addr  = base_q + k_q[MEM_AW-1:0];
  assign blk_valid = (st == ST_EMIT);
  assign busy      = (st != ST_IDLE);
  assign blk_idx   = k_q[IDX_W-1:0];
  assign blk_last  = busy && (k_q >= total_q - LEN_W'(BLK_WORDS));

  // R8: a stalled word keeps its address and stays offered
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && !blk_ready |=> blk_valid && $stable(mem_addr) && $stable(k_q));
  // R1: accepting the final word ends the message
  p_finish_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fire && final_word |=> !busy);
  // R1: after word 15 of a non-final block the index wraps
  p_idx_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !final_word && (blk_idx == IDX_W'(BLK_WORDS-1)) |=> blk_idx == '0);
  // R9: a start pulse while busy leaves the latched message alone
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(total_q) && $stable(base_q) && $stable(bytes_q));
endmodule

// File: rtl/msg_block_feeder.sv
module msg_block_feeder
  import mbf_pkg::*;
#(
  parameter int MEM_AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       msg_base,
  input  logic [31:0]       msg_bytes,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic [31:0]       mem_rdata,
  output logic              blk_valid,
  input  logic              blk_ready,
  output logic [31:0]       blk_word,
  output logic [IDX_W-1:0]  blk_idx,
  output logic              blk_last,
  output logic              busy
);
  logic [LEN_W-1:0] k_q, full_q, total_q, bytes_q;
  logic [1:0]       rem_q;
  logic             needs_mem, is_len_word;

  mbf_seq_ctrl #(.MEM_AW(MEM_AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .msg_base(msg_base),
    .msg_bytes(msg_bytes), .blk_ready(blk_ready), .mem_addr(mem_addr),
    .blk_valid(blk_valid), .busy(busy), .blk_last(blk_last), .blk_idx(blk_idx),
    .k_q(k_q), .full_q(full_q), .rem_q(rem_q), .total_q(total_q), .bytes_q(bytes_q)
  );

  mbf_word_former u_form (
    .k_idx(k_q), .full_words(full_q), .rem_bytes(rem_q), .total_words(total_q),
    .byte_len(bytes_q), .rdata(mem_rdata), .word(blk_word),
    .needs_mem(needs_mem), .is_len_word(is_len_word)
  );

  // R6: the length words never come from memory
  p_len_no_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && is_len_word |-> !needs_mem);
  // R7: the length field always lands in the final block
  p_len_in_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && is_len_word |-> blk_last);
  // R8: a stalled word keeps its value
  p_stall_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && !blk_ready |=> $stable(blk_word));
endmodule

// File: tb/sim_msg_block_feeder.sv
module sim_msg_block_feeder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] msg_base = '0;
  logic [31:0] msg_bytes = '0;
  logic [15:0] mem_addr;
  logic [31:0] mem_rdata;
  logic        blk_valid;
  logic        blk_ready = 1'b0;
  logic [31:0] blk_word;
  logic [3:0]  blk_idx;
  logic        blk_last;
  logic        busy;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  msg_block_feeder u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .msg_base(msg_base), .msg_bytes(msg_bytes),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .blk_valid(blk_valid), .blk_ready(blk_ready),
    .blk_word(blk_word), .blk_idx(blk_idx), .blk_last(blk_last), .busy(busy)
  );

  function automatic logic [31:0] mem_val(input logic [15:0] a);
    logic [7:0] i;
    i = a[7:0];
    return {i ^ 8'h5A, i + 8'd17, ~i, i * 8'd3};
  endfunction

  always_ff @(posedge clk) mem_rdata <= mem_val(mem_addr);

  // byte j of the padded message, built byte by byte
  function automatic logic [7:0] pad_byte(input int base, input int n, input int nblk, input int j);
    logic [31:0] w;
    logic [63:0] bl;
    int lenpos;
    lenpos = nblk * 64 - 8;
    bl = 64'(n) * 64'd8;
    if (j < n) begin
      w = mem_val(16'(base + j / 4));
      return w[8*(j%4) +: 8];
    end
    if (j == n) return 8'h80;
    if (j >= lenpos) return bl[8*(7-(j-lenpos)) +: 8];
    return 8'h00;
  endfunction

  function automatic logic [31:0] exp_word(input int base, input int n, input int nblk, input int k);
    return {pad_byte(base, n, nblk, 4*k), pad_byte(base, n, nblk, 4*k+1),
            pad_byte(base, n, nblk, 4*k+2), pad_byte(base, n, nblk, 4*k+3)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {base[15:0], bytes[31:0], blocks[7:0]}
  localparam int NV = 11;
  localparam logic [55:0] VEC [NV] = '{
    {16'd0,  32'd0,   8'd1}, {16'd4,  32'd3,   8'd1}, {16'd10, 32'd4,   8'd1},
    {16'd3,  32'd55,  8'd1}, {16'd20, 32'd56,  8'd2}, {16'd7,  32'd63,  8'd2},
    {16'd0,  32'd64,  8'd2}, {16'd30, 32'd113, 8'd2}, {16'd1,  32'd119, 8'd2},
    {16'd5,  32'd120, 8'd3}, {16'd40, 32'd112, 8'd2}
  };

  task automatic run_msg(input int base, input int n, input int nblk, input bit slow, input bit glitch);
    int got;
    int fails_before;
    string tag;
    fails_before = n_fail;
    got = 0;
    @(negedge clk);
    start = 1'b1; msg_base = 32'(base); msg_bytes = 32'(n);
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 6000; cyc++) begin
      if (!busy) break;
      blk_ready = slow ? ((cyc % 3) != 2) : 1'b1;
      if (glitch && cyc == 4) begin
        start = 1'b1; msg_base = 32'd0; msg_bytes = 32'd200;
      end else start = 1'b0;
      if (blk_valid && blk_ready) begin
        logic [31:0] e;
        e = exp_word(base, n, nblk, got);
        if (got < n / 4) tag = "R2";
        else if (got == n / 4 && (n % 4) != 0) tag = "R3";
        else if (got == n / 4) tag = "R4";
        else if (got >= nblk * 16 - 2) tag = "R6";
        else if (got >= (nblk - 1) * 16 && (n % 64) >= 56) tag = "R7";
        else tag = "R5";
        check(blk_word == e, tag, 64'(blk_word), 64'(e));
        check(blk_idx == 4'(got % 16) && blk_last == (got >= (nblk - 1) * 16), "R1 idx/last",
              {blk_idx, 3'b0, blk_last}, {4'(got % 16), 3'b0, 1'(got >= (nblk - 1) * 16)});
        if (n == 0 && got == 0) check(blk_word == 32'h8000_0000, "R11", 64'(blk_word), 64'h8000_0000);
        got++;
      end
      @(negedge clk);
    end
    start = 1'b0;
    blk_ready = 1'b0;
    check(got == nblk * 16, ((n % 64) >= 56) ? "R7 word count" : "R1 word count", 64'(got), 64'(nblk * 16));
    if (glitch) check(n_fail == fails_before, "R9 stream unaffected", 64'(n_fail - fails_before), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    // R10: reset state
    @(negedge clk);
    check(!blk_valid && !busy, "R10", {62'b0, blk_valid, busy}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!blk_valid && !busy, "R10", {62'b0, blk_valid, busy}, 64'd0);

    for (int v = 0; v < NV; v++) begin
      run_msg(int'(VEC[v][55:40]), int'(VEC[v][39:8]), int'(VEC[v][7:0]), v[0], v == 5);
    end

    // R8: latency and stall hold for an 8-byte message at base 50
    @(negedge clk);
    start = 1'b1; msg_base = 32'd50; msg_bytes = 32'd8; blk_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    check(!blk_valid, "R8 not yet valid", 64'(blk_valid), 64'd0);
    @(negedge clk);
    check(blk_valid && mem_addr == 16'd50, "R8 valid after read", {blk_valid, 47'b0, mem_addr}, {1'b1, 47'b0, 16'd50});
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      check(blk_valid && mem_addr == 16'd50 && blk_word == exp_word(50, 8, 1, 0), "R8 stall hold",
            {blk_valid, 15'b0, mem_addr, blk_word}, {1'b1, 15'b0, 16'd50, exp_word(50, 8, 1, 0)});
    end
    blk_ready = 1'b1;
    @(negedge clk);
    blk_ready = 1'b0;
    check(!blk_valid && mem_addr == 16'd51, "R8 next read", {blk_valid, 47'b0, mem_addr}, {1'b0, 47'b0, 16'd51});
    @(negedge clk);
    check(blk_valid && blk_word == exp_word(50, 8, 1, 1), "R8 second word", 64'(blk_word), 64'(exp_word(50, 8, 1, 1)));
    blk_ready = 1'b1;
    @(negedge clk);
    check(blk_valid && blk_word == 32'h8000_0000, "R4 no-read marker", 64'(blk_word), 64'h8000_0000);
    for (int c = 0; c < 40 && busy; c++) @(negedge clk);
    blk_ready = 1'b0;

    // R11: zero-length word is valid one cycle after start
    @(negedge clk);
    start = 1'b1; msg_base = 32'd9; msg_bytes = 32'd0;
    @(negedge clk);
    start = 1'b0;
    check(blk_valid && blk_word == 32'h8000_0000, "R11 latency", {31'b0, blk_valid, blk_word}, {31'b0, 1'b1, 32'h8000_0000});
    blk_ready = 1'b1;
    for (int c = 0; c < 40 && busy; c++) @(negedge clk);
    check(!busy, "R1 idle after drain", 64'(busy), 64'd0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule